// File: doc/BRIEF.md
# Serial Link Transaction Sequencer

This block runs one command/response exchange at a time on a two-wire serial management link. A host raises a request, and the sequencer tells a separate transceiver what to put on the wire: the prepared command frame, bursts of idle clocks, a data-poll, an error-poll or a terminate frame. It then asks the transceiver to collect the reply. The transceiver reports a receive result and a two-bit response tag, and the sequencer decides what comes next: it finishes, polls again, resends the whole command, or gives up. Every exchange ends with a turnaround burst of idle clocks before the host sees a one-cycle done pulse carrying a status code and the received data.

A slave that answers "busy" is polled again. Each data-poll is preceded by a fixed burst of idle clocks, because the slave can lock up when it is clocked fewer than about twenty times before a poll. A slave that stays busy past a limit is sent a terminate frame. A reply that fails its checksum is followed by an error-poll, up to a limit. A report from the slave that it received a corrupt command causes a full resend, up to a limit. A separate break request produces the link reset waveform and tells the address-tracking logic that its remembered address is stale. While an external-mode input hands the link pins to another controller, every request is refused at once.

Frame building, checksums and bit timing belong to the transceiver. The echo and turnaround delays are input ports, and a host typically programs both to 16. The retry limits and break lengths are parameters.

Top module: `link_txn_seq`

## Requirements
- R1: After reset, done_o, tx_start_o, rx_start_o and clr_addr_o are all low.
- R2: A transfer request issues a command op (tx_op_o = 1). It then issues an idle op (tx_op_o = 0) of echo_dly_i clocks, which is skipped when echo_dly_i is 0. Next comes a receive start with rx_data_exp_o equal to req_rd_i. A good reply with tag ACK (rx_res_i = 0, rx_tag_i = 0) is followed by an idle op of send_dly_i clocks, which is skipped when 0. Then done_o pulses with status 0 (ok) and data_o equal to the received data.
- R3: A good reply with tag BUSY (1), while fewer than BUSY_MAX data-polls have been sent for the current command, leads to an idle op of POLL_IDLE clocks. A data-poll op (2), an echo idle op and a new receive follow.
- R4: A BUSY tag after BUSY_MAX data-polls leads to an idle op of POLL_IDLE clocks, a terminate op (4), an echo idle op and a receive with rx_data_exp_o = 0. Whatever that reply is, the request ends with the send delay and status 2 (I/O error).
- R5: A reply with rx_res_i = 2 (checksum bad), while fewer than CRC_MAX error-polls have been sent, leads to an idle op of POLL_IDLE clocks, an error-poll op (3), an echo idle op and a new receive. Once CRC_MAX error-polls have been sent, the next such reply ends the request with status 2.
- R6: A reply tagged ERRC (3) leads to the send delay followed by a full resend starting with a new command op, at most CMD_MAX times per request. The busy and error-poll counts restart with each resend. An ERRC beyond that limit ends the request with status 2.
- R7: A reply tagged ERRA (2) ends the request after the send delay with status 2.
- R8: rx_res_i = 1 (no start bit) ends the request with status 1 (timeout). rx_res_i = 3 (all-ones reply) ends it with status 3 (no device). Both end after the send delay.
- R9: A break request issues an idle op of PRE_BRK clocks, a drive-low op (5) of BRK_LEN clocks, an idle op of echo_dly_i clocks and an idle op of POST_BRK clocks. No send delay follows. done_o then pulses with status 0 and clr_addr_o high in the same cycle.
- R10: A request accepted while ext_mode_i is high issues no link op. done_o pulses in the next cycle with status 4 (refused).
- R11: done_o is high for exactly one cycle per request, and data_o is zero whenever the status is not ok.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_mode_i | input | 1 | Link pins belong to another controller; refuse requests |
| echo_dly_i | input | CNT_W | Idle clocks after every sent frame |
| send_dly_i | input | CNT_W | Turnaround idle clocks at the end of every exchange |
| req_valid_i | input | 1 | Request pulse, taken only while the sequencer is idle |
| req_brk_i | input | 1 | Request is a link break rather than a transfer |
| req_id_i | input | ID_W | Slave identifier for the transfer |
| req_rd_i | input | 1 | Transfer expects a data payload in the reply |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | 0 ok, 1 timeout, 2 I/O error, 3 no device, 4 refused |
| data_o | output | DATA_W | Received payload, valid with done_o |
| clr_addr_o | output | 1 | Remembered link address is stale (pulses with break completion) |
| tx_start_o | output | 1 | Start one transceiver op |
| tx_op_o | output | 3 | 0 idle, 1 command, 2 data-poll, 3 error-poll, 4 terminate, 5 drive low |
| tx_cnt_o | output | CNT_W | Clock count for idle and drive-low ops |
| tx_id_o | output | ID_W | Slave identifier for poll and terminate frames |
| tx_done_i | input | 1 | Transceiver finished the current op |
| rx_start_o | output | 1 | Start collecting one reply |
| rx_data_exp_o | output | 1 | Reply carries a data payload on ACK |
| rx_done_i | input | 1 | Reply collected |
| rx_res_i | input | 2 | 0 good, 1 timeout, 2 checksum bad, 3 all ones |
| rx_tag_i | input | 2 | 0 ACK, 1 BUSY, 2 ERRA, 3 ERRC |
| rx_data_i | input | DATA_W | Received payload |

## Verification
The bench builds the sequencer with BUSY_MAX = 2, CRC_MAX = 2 and CMD_MAX = 1. With these values a few scripted replies are enough to reach the terminate escalation, the exhausted error-poll path and the exhausted resend path. The break lengths are shortened to 6, 10 and 4 clocks, so the full break waveform is checked op by op. POLL_IDLE stays at 21. The scoreboard can therefore confirm the exact idle count that precedes each poll. The echo and turnaround inputs are changed between requests, including a zero echo that must be skipped.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_CMD   = 3'd1,
        OP_DPOLL = 3'd2,
        OP_EPOLL = 3'd3,
        OP_TERM  = 3'd4,
        OP_LOW   = 3'd5
    } link_op_e;

    typedef enum logic [2:0] {
        XS_OK      = 3'd0,
        XS_TIMEOUT = 3'd1,
        XS_IOERR   = 3'd2,
        XS_NODEV   = 3'd3,
        XS_REFUSED = 3'd4
    } xfer_st_e;

    typedef enum logic [1:0] {
        RX_GOOD    = 2'd0,
        RX_TIMEOUT = 2'd1,
        RX_CRCBAD  = 2'd2,
        RX_ONES    = 2'd3
    } rx_res_e;

    typedef enum logic [1:0] {
        TAG_ACK  = 2'd0,
        TAG_BUSY = 2'd1,
        TAG_ERRA = 2'd2,
        TAG_ERRC = 2'd3
    } resp_tag_e;

    typedef enum logic [2:0] {
        ACT_OK,
        ACT_TIMEOUT,
        ACT_NODEV,
        ACT_CRC,
        ACT_BUSY,
        ACT_ERRA,
        ACT_ERRC
    } resp_act_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CMD,
        S_ECHO,
        S_RX,
        S_PRE,
        S_POLL,
        S_SDLY,
        S_BRK_PRE,
        S_BRK_LOW,
        S_BRK_ECHO,
        S_BRK_POST,
        S_FIN
    } seq_st_e;

endpackage

// File: rtl/seq_resp_cls.sv
module seq_resp_cls
    import seq_pkg::*;
(
    input  logic [1:0] res_i,
    input  logic [1:0] tag_i,
    output resp_act_e  act_o
);

    always_comb begin
        act_o = ACT_OK;
        unique case (rx_res_e'(res_i))
            RX_TIMEOUT: act_o = ACT_TIMEOUT;
            RX_ONES:    act_o = ACT_NODEV;
            RX_CRCBAD:  act_o = ACT_CRC;
            default: begin
                unique case (resp_tag_e'(tag_i))
                    TAG_BUSY: act_o = ACT_BUSY;
                    TAG_ERRA: act_o = ACT_ERRA;
                    TAG_ERRC: act_o = ACT_ERRC;
                    default:  act_o = ACT_OK;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/seq_lim_ctr.sv
module seq_lim_ctr #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_lim_o
);

    localparam int CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    assign at_lim_o = (cnt_q == CW'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && !at_lim_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3 R5 R6
    lim_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT));

    // R3 R5 R6
    lim_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && !at_lim_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/link_txn_seq.sv
module link_txn_seq
    import seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 12,
    parameter int ID_W      = 2,
    parameter int BUSY_MAX  = 50,
    parameter int CRC_MAX   = 3,
    parameter int CMD_MAX   = 3,
    parameter int POLL_IDLE = 21,
    parameter int PRE_BRK   = 50,
    parameter int BRK_LEN   = 256,
    parameter int POST_BRK  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode_i,
    input  logic [CNT_W-1:0]  echo_dly_i,
    input  logic [CNT_W-1:0]  send_dly_i,
    input  logic              req_valid_i,
    input  logic              req_brk_i,
    input  logic [ID_W-1:0]   req_id_i,
    input  logic              req_rd_i,
    output logic              done_o,
    output logic [2:0]        status_o,
    output logic [DATA_W-1:0] data_o,
    output logic              clr_addr_o,
    output logic              tx_start_o,
    output logic [2:0]        tx_op_o,
    output logic [CNT_W-1:0]  tx_cnt_o,
    output logic [ID_W-1:0]   tx_id_o,
    input  logic              tx_done_i,
    output logic              rx_start_o,
    output logic              rx_data_exp_o,
    input  logic              rx_done_i,
    input  logic [1:0]        rx_res_i,
    input  logic [1:0]        rx_tag_i,
    input  logic [DATA_W-1:0] rx_data_i
);

    localparam logic [CNT_W-1:0] POLL_CNT = CNT_W'(POLL_IDLE);
    localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(PRE_BRK);
    localparam logic [CNT_W-1:0] BRK_CNT  = CNT_W'(BRK_LEN);
    localparam logic [CNT_W-1:0] POST_CNT = CNT_W'(POST_BRK);

    typedef struct packed {
        seq_st_e           st;
        logic              issued;
        logic [ID_W-1:0]   id;
        logic              rd;
        logic              brk;
        logic              resend;
        logic              term;
        link_op_e          poll_op;
        xfer_st_e          status;
        logic [DATA_W-1:0] data;
    } seq_reg_t;

    seq_reg_t r_q, r_d;

    resp_act_e act;
    logic      busy_inc, crc_inc, cmd_inc;
    logic      poll_clr, cmd_clr;
    logic      busy_lim, crc_lim, cmd_lim;

    logic              is_tx, counted, adv;
    seq_st_e           nxt;
    link_op_e          op_c;
    logic [CNT_W-1:0]  cnt_c;
    logic              tx_start_c, rx_start_c;

    seq_resp_cls u_cls (
        .res_i (rx_res_i),
        .tag_i (rx_tag_i),
        .act_o (act)
    );

    seq_lim_ctr #(.LIMIT(BUSY_MAX)) u_busy_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (poll_clr),
        .inc_i    (busy_inc),
        .at_lim_o (busy_lim)
    );

    seq_lim_ctr #(.LIMIT(CRC_MAX)) u_crc_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (poll_clr),
        .inc_i    (crc_inc),
        .at_lim_o (crc_lim)
    );

    seq_lim_ctr #(.LIMIT(CMD_MAX)) u_cmd_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (cmd_clr),
        .inc_i    (cmd_inc),
        .at_lim_o (cmd_lim)
    );

    // op and count chosen by the present state
    always_comb begin
        is_tx   = 1'b0;
        counted = 1'b0;
        op_c    = OP_IDLE;
        cnt_c   = '0;
        nxt     = r_q.st;
        unique case (r_q.st)
            S_CMD: begin
                is_tx = 1'b1;
                op_c  = OP_CMD;
                nxt   = S_ECHO;
            end
            S_ECHO: begin
                is_tx   = 1'b1;
                counted = 1'b1;
                cnt_c   = echo_dly_i;
                nxt     = S_RX;
            end
            S_PRE: begin
                is_tx   = 1'b1;
                counted = 1'b1;
                cnt_c   = POLL_CNT;
                nxt     = S_POLL;
            end
            S_POLL: begin
                is_tx = 1'b1;
                op_c  = r_q.poll_op;
                nxt   = S_ECHO;
            end
            S_SDLY: begin
                is_tx   = 1'b1;
                counted = 1'b1;
                cnt_c   = send_dly_i;
                nxt     = r_q.resend ? S_CMD : S_FIN;
            end
            S_BRK_PRE: begin
                is_tx   = 1'b1;
                counted = 1'b1;
                cnt_c   = PRE_CNT;
                nxt     = S_BRK_LOW;
            end
            S_BRK_LOW: begin
                is_tx   = 1'b1;
                counted = 1'b1;
                op_c    = OP_LOW;
                cnt_c   = BRK_CNT;
                nxt     = S_BRK_ECHO;
            end
            S_BRK_ECHO: begin
                is_tx   = 1'b1;
                counted = 1'b1;
                cnt_c   = echo_dly_i;
                nxt     = S_BRK_POST;
            end
            S_BRK_POST: begin
                is_tx   = 1'b1;
                counted = 1'b1;
                cnt_c   = POST_CNT;
                nxt     = S_FIN;
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        r_d        = r_q;
        tx_start_c = 1'b0;
        rx_start_c = 1'b0;
        adv        = 1'b0;
        busy_inc   = 1'b0;
        crc_inc    = 1'b0;
        cmd_inc    = 1'b0;
        poll_clr   = 1'b0;
        cmd_clr    = 1'b0;

        if (is_tx) begin
            if (counted && cnt_c == '0) begin
                adv = 1'b1;
            end else if (!r_q.issued) begin
                tx_start_c = 1'b1;
                r_d.issued = 1'b1;
            end else if (tx_done_i) begin
                adv        = 1'b1;
                r_d.issued = 1'b0;
            end
            if (adv) begin
                r_d.st = nxt;
                if (r_q.st == S_SDLY && r_q.resend) begin
                    r_d.resend = 1'b0;
                    poll_clr   = 1'b1;
                end
            end
        end

        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid_i) begin
                    r_d.data   = '0;
                    r_d.issued = 1'b0;
                    r_d.resend = 1'b0;
                    r_d.term   = 1'b0;
                    if (ext_mode_i) begin
                        r_d.status = XS_REFUSED;
                        r_d.brk    = 1'b0;
                        r_d.st     = S_FIN;
                    end else begin
                        r_d.status = XS_OK;
                        r_d.id     = req_id_i;
                        r_d.rd     = req_rd_i;
                        r_d.brk    = req_brk_i;
                        poll_clr   = 1'b1;
                        cmd_clr    = 1'b1;
                        r_d.st     = req_brk_i ? S_BRK_PRE : S_CMD;
                    end
                end
            end
            S_RX: begin
                if (!r_q.issued) begin
                    rx_start_c = 1'b1;
                    r_d.issued = 1'b1;
                end else if (rx_done_i) begin
                    r_d.issued = 1'b0;
                    r_d.st     = S_SDLY;
                    if (r_q.term) begin
                        r_d.status = XS_IOERR;
                    end else begin
                        unique case (act)
                            ACT_OK: begin
                                r_d.status = XS_OK;
                                r_d.data   = rx_data_i;
                            end
                            ACT_TIMEOUT: r_d.status = XS_TIMEOUT;
                            ACT_NODEV:   r_d.status = XS_NODEV;
                            ACT_ERRA:    r_d.status = XS_IOERR;
                            ACT_CRC: begin
                                if (!crc_lim) begin
                                    crc_inc     = 1'b1;
                                    r_d.poll_op = OP_EPOLL;
                                    r_d.st      = S_PRE;
                                end else begin
                                    r_d.status = XS_IOERR;
                                end
                            end
                            ACT_BUSY: begin
                                r_d.st = S_PRE;
                                if (!busy_lim) begin
                                    busy_inc    = 1'b1;
                                    r_d.poll_op = OP_DPOLL;
                                end else begin
                                    r_d.poll_op = OP_TERM;
                                    r_d.term    = 1'b1;
                                end
                            end
                            ACT_ERRC: begin
                                if (!cmd_lim) begin
                                    cmd_inc    = 1'b1;
                                    r_d.resend = 1'b1;
                                end else begin
                                    r_d.status = XS_IOERR;
                                end
                            end
                            default: r_d.status = XS_IOERR;
                        endcase
                    end
                end
            end
            S_FIN: begin
                r_d.st = S_IDLE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, poll_op: OP_DPOLL, status: XS_OK, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_start_o    = tx_start_c;
    assign tx_op_o       = op_c;
    assign tx_cnt_o      = cnt_c;
    assign tx_id_o       = r_q.id;
    assign rx_start_o    = rx_start_c;
    assign rx_data_exp_o = r_q.rd & ~r_q.term;
    assign done_o        = (r_q.st == S_FIN);
    assign status_o      = r_q.status;
    assign data_o        = r_q.data;
    assign clr_addr_o    = (r_q.st == S_FIN) & r_q.brk;

    // record of the last issued op, kept only for the poll-gap property
    link_op_e         last_op_q;
    logic [CNT_W-1:0] last_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_op_q  <= OP_CMD;
            last_cnt_q <= '0;
        end else if (tx_start_o) begin
            last_op_q  <= link_op_e'(tx_op_o);
            last_cnt_q <= tx_cnt_o;
        end
    end

    // R3
    poll_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start_o && tx_op_o == OP_DPOLL) |-> (last_op_q == OP_IDLE && last_cnt_q == POLL_CNT));

    // R2
    start_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_start_o && rx_start_o));

    // R10
    refuse_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_IDLE && req_valid_i && ext_mode_i) |=> (done_o && status_o == XS_REFUSED));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    err_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && status_o != XS_OK) |-> (data_o == '0));

    // R9
    brk_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_addr_o |-> (done_o && status_o == XS_OK));

endmodule

// File: tb/link_txn_seq_tb.sv
module link_txn_seq_tb;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;
    localparam int ID_W   = 2;
    localparam int BMAX   = 2;
    localparam int CMAX   = 2;
    localparam int RMAX   = 1;
    localparam int PIDLE  = 21;
    localparam int PRE    = 6;
    localparam int BLEN   = 10;
    localparam int POST   = 4;

    localparam int K_TX = 0, K_RX = 1, K_DONE = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ext_mode_i = 1'b0;
    logic [CNT_W-1:0]  echo_dly_i = 12'd16;
    logic [CNT_W-1:0]  send_dly_i = 12'd16;
    logic              req_valid_i = 1'b0;
    logic              req_brk_i = 1'b0;
    logic [ID_W-1:0]   req_id_i = 2'd1;
    logic              req_rd_i = 1'b0;
    logic              done_o;
    logic [2:0]        status_o;
    logic [DATA_W-1:0] data_o;
    logic              clr_addr_o;
    logic              tx_start_o;
    logic [2:0]        tx_op_o;
    logic [CNT_W-1:0]  tx_cnt_o;
    logic [ID_W-1:0]   tx_id_o;
    logic              tx_done_i = 1'b0;
    logic              rx_start_o;
    logic              rx_data_exp_o;
    logic              rx_done_i = 1'b0;
    logic [1:0]        rx_res_i = 2'd0;
    logic [1:0]        rx_tag_i = 2'd0;
    logic [DATA_W-1:0] rx_data_i = '0;

    always #2.5 clk = ~clk;

    link_txn_seq #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .ID_W(ID_W),
        .BUSY_MAX(BMAX), .CRC_MAX(CMAX), .CMD_MAX(RMAX),
        .POLL_IDLE(PIDLE), .PRE_BRK(PRE), .BRK_LEN(BLEN), .POST_BRK(POST)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i),
        .echo_dly_i(echo_dly_i), .send_dly_i(send_dly_i),
        .req_valid_i(req_valid_i), .req_brk_i(req_brk_i),
        .req_id_i(req_id_i), .req_rd_i(req_rd_i),
        .done_o(done_o), .status_o(status_o), .data_o(data_o),
        .clr_addr_o(clr_addr_o),
        .tx_start_o(tx_start_o), .tx_op_o(tx_op_o), .tx_cnt_o(tx_cnt_o),
        .tx_id_o(tx_id_o), .tx_done_i(tx_done_i),
        .rx_start_o(rx_start_o), .rx_data_exp_o(rx_data_exp_o),
        .rx_done_i(rx_done_i), .rx_res_i(rx_res_i), .rx_tag_i(rx_tag_i),
        .rx_data_i(rx_data_i)
    );

    typedef struct {
        int    kind;
        int    op;
        int    cnt;
        int    st;
        int    dat;
        int    flag;
        string tag;
    } exp_t;

    typedef struct {
        int res;
        int tg;
        int dat;
    } rsp_t;

    exp_t expq[$];
    rsp_t rspq[$];
    int   nchk = 0;
    int   nfail = 0;
    int   ndone = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push_tx(input int op, input int cnt, input string tag);
        exp_t e;
        e.kind = K_TX; e.op = op; e.cnt = cnt; e.st = 0; e.dat = 0; e.flag = 0; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic push_echo(input string tag);
        if (echo_dly_i != 0) push_tx(0, int'(echo_dly_i), tag);
    endtask

    task automatic push_sdly(input string tag);
        if (send_dly_i != 0) push_tx(0, int'(send_dly_i), tag);
    endtask

    task automatic push_rx(input int dexp, input string tag);
        exp_t e;
        e.kind = K_RX; e.op = 0; e.cnt = 0; e.st = 0; e.dat = 0; e.flag = dexp; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic push_done(input int st, input int dat, input int clr, input string tag);
        exp_t e;
        e.kind = K_DONE; e.op = 0; e.cnt = 0; e.st = st; e.dat = dat; e.flag = clr; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic push_rsp(input int res, input int tg, input int dat);
        rsp_t r;
        r.res = res; r.tg = tg; r.dat = dat;
        rspq.push_back(r);
    endtask

    // command, echo, receive
    task automatic push_cmd(input int dexp, input string tag);
        push_tx(1, -1, tag);
        push_echo(tag);
        push_rx(dexp, tag);
    endtask

    // idle burst, poll frame, echo, receive
    task automatic push_poll(input int op, input int dexp, input string tag);
        push_tx(0, PIDLE, tag);
        push_tx(op, -1, tag);
        push_echo(tag);
        push_rx(dexp, tag);
    endtask

    // monitor and transceiver model
    int   tx_cd = 0;
    int   rx_cd = 0;
    rsp_t cur_rsp;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (tx_start_o) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R2", "unexpected tx op", tx_op_o, 0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(e.kind == K_TX, e.tag, "item kind (tx seen)", K_TX, e.kind);
                        chk(int'(tx_op_o) == e.op, e.tag, "tx op", tx_op_o, e.op);
                        if (e.cnt >= 0)
                            chk(int'(tx_cnt_o) == e.cnt, e.tag, "tx count", tx_cnt_o, e.cnt);
                    end
                    tx_cd = 3;
                end
                if (rx_start_o) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R2", "unexpected rx start", 1, 0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(e.kind == K_RX, e.tag, "item kind (rx seen)", K_RX, e.kind);
                        chk(int'(rx_data_exp_o) == e.flag, e.tag, "rx data expected",
                            rx_data_exp_o, e.flag);
                    end
                    if (rspq.size() == 0) begin
                        chk(1'b0, "R2", "no scripted reply", 0, 1);
                        cur_rsp.res = 1; cur_rsp.tg = 0; cur_rsp.dat = 0;
                    end else begin
                        cur_rsp = rspq.pop_front();
                    end
                    rx_cd = 3;
                end
                if (done_o) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "R11", "unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(e.kind == K_DONE, e.tag, "item kind (done seen)", K_DONE, e.kind);
                        chk(int'(status_o) == e.st, e.tag, "status", status_o, e.st);
                        chk(data_o == DATA_W'(e.dat), e.tag, "data", data_o, e.dat);
                        chk(int'(clr_addr_o) == e.flag, e.tag, "addr clear", clr_addr_o, e.flag);
                    end
                    ndone++;
                end
            end
            tx_done_i = 1'b0;
            rx_done_i = 1'b0;
            if (tx_cd > 0) begin
                tx_cd--;
                if (tx_cd == 1) tx_done_i = 1'b1;
            end
            if (rx_cd > 0) begin
                rx_cd--;
                if (rx_cd == 1) begin
                    rx_done_i = 1'b1;
                    rx_res_i  = 2'(cur_rsp.res);
                    rx_tag_i  = 2'(cur_rsp.tg);
                    rx_data_i = DATA_W'(cur_rsp.dat);
                end
            end
        end
    end

    task automatic run_req(input bit brk, input bit rd, input string tag);
        int start;
        bit got;
        start = ndone;
        got   = 1'b0;
        @(negedge clk);
        req_valid_i = 1'b1;
        req_brk_i   = brk;
        req_rd_i    = rd;
        @(negedge clk);
        req_valid_i = 1'b0;
        for (int i = 0; i < 4000 && !got; i++) begin
            if (ndone > start) got = 1'b1;
            else @(negedge clk);
        end
        if (!got) chk(1'b0, tag, "watchdog: no done", 0, 1);
        repeat (3) @(negedge clk);
        chk(expq.size() == 0, tag, "leftover expected items", expq.size(), 0);
        expq.delete();
        rspq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        chk(tx_start_o == 1'b0 && rx_start_o == 1'b0, "R1", "starts in reset",
            {tx_start_o, rx_start_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clr_addr_o == 1'b0 && done_o == 1'b0, "R1", "idle after reset",
            {clr_addr_o, done_o}, 0);

        // R2 read with ACK
        push_cmd(1, "R2");
        push_rsp(0, 0, 32'hA5A51234);
        push_sdly("R2");
        push_done(0, 32'hA5A51234, 0, "R2");
        run_req(1'b0, 1'b1, "R2");

        // R2 write, zero echo skipped, short send delay
        echo_dly_i = 12'd0;
        send_dly_i = 12'd3;
        push_cmd(0, "R2");
        push_rsp(0, 0, 0);
        push_sdly("R2");
        push_done(0, 0, 0, "R2");
        run_req(1'b0, 1'b0, "R2");
        echo_dly_i = 12'd16;
        send_dly_i = 12'd16;

        // R3 busy twice then ACK
        push_cmd(1, "R3");
        push_rsp(0, 1, 0);
        push_poll(2, 1, "R3");
        push_rsp(0, 1, 0);
        push_poll(2, 1, "R3");
        push_rsp(0, 0, 32'h0BADCAFE);
        push_sdly("R3");
        push_done(0, 32'h0BADCAFE, 0, "R3");
        run_req(1'b0, 1'b1, "R3");

        // R4 busy beyond limit escalates to terminate
        push_cmd(1, "R4");
        push_rsp(0, 1, 0);
        push_poll(2, 1, "R4");
        push_rsp(0, 1, 0);
        push_poll(2, 1, "R4");
        push_rsp(0, 1, 0);
        push_poll(4, 0, "R4");
        push_rsp(0, 0, 0);
        push_sdly("R4");
        push_done(2, 0, 0, "R4");
        run_req(1'b0, 1'b1, "R4");

        // R5 checksum errors recovered by error-poll
        push_cmd(1, "R5");
        push_rsp(2, 0, 0);
        push_poll(3, 1, "R5");
        push_rsp(2, 0, 0);
        push_poll(3, 1, "R5");
        push_rsp(0, 0, 32'h13572468);
        push_sdly("R5");
        push_done(0, 32'h13572468, 0, "R5");
        run_req(1'b0, 1'b1, "R5");

        // R5 checksum errors exhaust the limit
        push_cmd(1, "R5");
        push_rsp(2, 0, 0);
        push_poll(3, 1, "R5");
        push_rsp(2, 0, 0);
        push_poll(3, 1, "R5");
        push_rsp(2, 0, 0);
        push_sdly("R5");
        push_done(2, 0, 0, "R5");
        run_req(1'b0, 1'b1, "R5");

        // R6 command checksum report: one resend, busy count restarts
        push_cmd(1, "R6");
        push_rsp(0, 1, 0);
        push_poll(2, 1, "R6");
        push_rsp(0, 1, 0);
        push_poll(2, 1, "R6");
        push_rsp(0, 3, 0);
        push_sdly("R6");
        push_cmd(1, "R6");
        push_rsp(0, 1, 0);
        push_poll(2, 1, "R6");
        push_rsp(0, 0, 32'h00C0FFEE);
        push_sdly("R6");
        push_done(0, 32'h00C0FFEE, 0, "R6");
        run_req(1'b0, 1'b1, "R6");

        // R6 resend limit exhausted
        push_cmd(0, "R6");
        push_rsp(0, 3, 0);
        push_sdly("R6");
        push_cmd(0, "R6");
        push_rsp(0, 3, 0);
        push_sdly("R6");
        push_done(2, 0, 0, "R6");
        run_req(1'b0, 1'b0, "R6");

        // R7 ERRA
        push_cmd(1, "R7");
        push_rsp(0, 2, 32'hFFFF);
        push_sdly("R7");
        push_done(2, 0, 0, "R7");
        run_req(1'b0, 1'b1, "R7");

        // R8 timeout and no device
        push_cmd(1, "R8");
        push_rsp(1, 0, 0);
        push_sdly("R8");
        push_done(1, 0, 0, "R8");
        run_req(1'b0, 1'b1, "R8");
        push_cmd(1, "R8");
        push_rsp(3, 3, 32'hFFFFFFFF);
        push_sdly("R8");
        push_done(3, 0, 0, "R8");
        run_req(1'b0, 1'b1, "R8");

        // R9 break waveform
        echo_dly_i = 12'd7;
        push_tx(0, PRE, "R9");
        push_tx(5, BLEN, "R9");
        push_tx(0, 7, "R9");
        push_tx(0, POST, "R9");
        push_done(0, 0, 1, "R9");
        run_req(1'b1, 1'b0, "R9");
        echo_dly_i = 12'd16;

        // R10 external mode refuses transfer and break
        ext_mode_i = 1'b1;
        push_done(4, 0, 0, "R10");
        run_req(1'b0, 1'b1, "R10");
        push_done(4, 0, 0, "R10");
        run_req(1'b1, 1'b0, "R10");
        ext_mode_i = 1'b0;

        // R11 normal service resumes after refusal
        push_cmd(1, "R11");
        push_rsp(0, 0, 32'h55AA55AA);
        push_sdly("R11");
        push_done(0, 32'h55AA55AA, 0, "R11");
        run_req(1'b0, 1'b1, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule